// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is one PWM timer driving an output pair, A and B, from a signed 16-bit counter. Six compare values and an initial-count value are written by software through a small register port. Every write lands in a shadow copy. The shadow copy moves into the active copy that the counter and comparators use only when two conditions hold: software has raised a load-okay flag, and the block has reached a permitted load point. This lets software change the period and the duty cycle without producing a torn waveform.

Load points are set by a control register. In immediate mode a commit follows the load-okay flag at once. In cycle mode the load points are matches on compare 1 (the full-cycle point, where the counter also wraps to its initial value) and/or compare 0 (the half-cycle point). A load-frequency field makes the block wait for 1 to 16 such opportunities before each reload cycle. Status flags report compare matches, reload cycles, missed commits and pending shadow data. Any enabled flag raises a single interrupt line. The counter advances on clock-enable ticks from a power-of-two prescaler, and only while the run input is high.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: The counter changes only on a tick. On a tick it loads the active initial count when it equals active compare 1, and otherwise adds one. With the run input low it holds its value.
- R2: With prescaler field p (control bits 2:0), a run of K consecutive clocks with the run input high gives floor(K / 2^p) ticks. The prescaler phase restarts whenever the run input is low.
- R3: Writes to address 0 (initial count) and addresses 1 to 6 (compare 0 to 5) update the shadow copy, which reads back at the same address. The active copy stays unchanged until a commit.
- R4: In cycle mode (control bit 3 = 0), a tick on a match with compare 1 is an opportunity when bit 4 is set, and a tick on a match with compare 0 is an opportunity when bit 5 is set. Every (L+1)-th opportunity, where L is control bits 9:6, is a reload cycle. A reload cycle commits the shadow copy only if load-okay is set.
- R5: In immediate mode (control bit 3 = 1), a commit happens on the first clock edge at which load-okay is already set.
- R6: Load-okay is set by the set input and cleared by the clear input, which wins. It is also cleared after a commit. A write to the initial count is ignored while load-okay is set.
- R7: On a tick, a match with compare 2 sets A and a match with compare 3 clears A. A match with compare 4 sets B and a match with compare 5 clears B. When a set and a clear coincide, the clear wins.
- R8: With control bit 10 (independent) clear, output B is the inverse of A's internal state. With it set, B follows its own compare registers.
- R9: Output A is forced low while control bit 11 is clear. Output B is forced low while control bit 12 is clear.
- R10: Status register (address 8): bits 0 to 5 are compare-match flags, and bit 14 reads 1 while accepted shadow writes have not been committed. Writing 1 to bits 0 to 5, 12 or 13 clears them. Bit 14 ignores writes.
- R11: Status bit 12 is set on every reload cycle. Bit 13 is set on a reload cycle that finds shadow data pending and load-okay clear.
- R12: The interrupt output is high while any status flag in bits 0 to 5, 12 or 13 is set together with the same bit of the interrupt-enable register (address 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| run_i | input | 1 | Counter run enable |
| ldok_set_i | input | 1 | Set load-okay |
| ldok_clr_i | input | 1 | Clear load-okay |
| ldok_o | output | 1 | Current load-okay flag |
| cnt_o | output | 16 | Current counter value |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The first is a compare 2 set and a compare 3 clear on one count value. The bench sets both registers to the same value while A is low, runs the counter through that count, and judges that A stays low. The second is a reload cycle that arrives while shadow data is pending. The bench runs it once with load-okay clear and expects the error flag. It runs it again with load-okay set and expects a commit with no error, with the load-okay and pending flags both dropping on that same tick.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  // register addresses
  localparam int A_INIT = 0;
  localparam int A_CMP0 = 1;
  localparam int A_CTRL = 7;
  localparam int A_STS  = 8;
  localparam int A_IEN  = 9;
  localparam int A_CNT  = 10;
  // control field positions
  localparam int C_PSC   = 0;
  localparam int C_IMM   = 3;
  localparam int C_FULL  = 4;
  localparam int C_HALF  = 5;
  localparam int C_LDFQ  = 6;
  localparam int C_INDEP = 10;
  localparam int C_ENA   = 11;
  localparam int C_ENB   = 12;
  // status bit positions
  localparam int S_RLD  = 12;
  localparam int S_RERR = 13;
  localparam int S_PEND = 14;
  localparam int NCMP   = 6;
endpackage

// File: rtl/pwm_tmr_presc.sv
module pwm_tmr_presc #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = (2 ** PSC_W) - 1;

  logic [DIV_W-1:0] div_q, mask;

  assign mask   = (DIV_W'(1) << psc_i) - DIV_W'(1);
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (div_q == '0)); // R2
endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs import pwm_tmr_pkg::*; #(
  parameter int DW     = 16,
  parameter int ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 ldok_set_i,
  input  logic                 ldok_clr_i,
  input  logic                 imm_i,
  input  logic                 rld_cyc_i,
  output logic                 ldok_o,
  output logic                 pend_o,
  output logic [DW-1:0]        init_sh_o,
  output logic [DW-1:0]        init_act_o,
  output logic [NCMP-1:0][DW-1:0] cmp_sh_o,
  output logic [NCMP-1:0][DW-1:0] cmp_act_o
);
  logic ldok_q, pend_q, commit, wr_init;
  logic [NCMP-1:0] wr_cmp;
  logic [DW-1:0] init_sh_q, init_act_q;
  logic [NCMP-1:0][DW-1:0] cmp_sh_q, cmp_act_q;

  assign commit  = ldok_q && (imm_i || rld_cyc_i);
  assign wr_init = wr_en_i && (addr_i == ADDR_W'(A_INIT)) && !ldok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_sh_q  <= '0;
      init_act_q <= '0;
    end else begin
      if (wr_init) init_sh_q  <= wdata_i;
      if (commit)  init_act_q <= init_sh_q;
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign wr_cmp[k] = wr_en_i && (addr_i == ADDR_W'(A_CMP0 + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_sh_q[k]  <= '0;
        cmp_act_q[k] <= '0;
      end else begin
        if (wr_cmp[k]) cmp_sh_q[k]  <= wdata_i;
        if (commit)    cmp_act_q[k] <= cmp_sh_q[k];
      end
    end
  end

  // clear input beats set, set beats hardware clear on commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldok_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ldok_clr_i)      ldok_q <= 1'b0;
      else if (ldok_set_i) ldok_q <= 1'b1;
      else if (commit)     ldok_q <= 1'b0;
      if (wr_init || (|wr_cmp)) pend_q <= 1'b1;
      else if (commit)          pend_q <= 1'b0;
    end
  end

  assign ldok_o     = ldok_q;
  assign pend_o     = pend_q;
  assign init_sh_o  = init_sh_q;
  assign init_act_o = init_act_q;
  assign cmp_sh_o   = cmp_sh_q;
  assign cmp_act_o  = cmp_act_q;

  AST_INIT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_INIT) && ldok_q) |=> $stable(init_sh_q)); // R6
  AST_LDOK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldok_clr_i |=> !ldok_q); // R6
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(init_act_q) && $stable(cmp_act_q))); // R3
  AST_COMMIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !ldok_set_i) |=> !ldok_q); // R6
endmodule

// File: rtl/pwm_tmr_outs.sv
module pwm_tmr_outs import pwm_tmr_pkg::*; #(
  parameter int DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [DW-1:0]    cnt_i,
  input  logic [NCMP-1:0][DW-1:0] cmp_i,
  input  logic                    indep_i,
  input  logic                    en_a_i,
  input  logic                    en_b_i,
  output logic [NCMP-1:0]         match_o,
  output logic                    pwm_a_o,
  output logic                    pwm_b_o
);
  logic raw_a_q, raw_b_q;

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    assign match_o[k] = tick_i && (cnt_i == $signed(cmp_i[k]));
  end

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_a_q <= 1'b0;
      raw_b_q <= 1'b0;
    end else begin
      if (match_o[3])      raw_a_q <= 1'b0;
      else if (match_o[2]) raw_a_q <= 1'b1;
      if (match_o[5])      raw_b_q <= 1'b0;
      else if (match_o[4]) raw_b_q <= 1'b1;
    end
  end

  assign pwm_a_o = en_a_i && raw_a_q;
  assign pwm_b_o = en_b_i && (indep_i ? raw_b_q : !raw_a_q);

  AST_CLR_WINS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o[3] |=> !raw_a_q); // R7
  AST_CLR_WINS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o[5] |=> !raw_b_q); // R7
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer import pwm_tmr_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int LDFQ_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              run_i,
  input  logic              ldok_set_i,
  input  logic              ldok_clr_i,
  output logic              ldok_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] FLAG_MASK =
    CNT_W'((1 << NCMP) - 1) | (CNT_W'(1) << S_RLD) | (CNT_W'(1) << S_RERR);

  logic [CNT_W-1:0] ctrl_q, sts_q, ien_q, sts_set, sts_clr, sts_view;
  logic signed [CNT_W-1:0] cnt_q;
  logic [LDFQ_W-1:0] opp_q;
  logic tick, opp, rld_cyc, ldok, pend;
  logic [NCMP-1:0] match;
  logic [CNT_W-1:0] init_sh, init_act;
  logic [NCMP-1:0][CNT_W-1:0] cmp_sh, cmp_act;

  pwm_tmr_presc #(.PSC_W(PSC_W)) i_presc (
    .clk_i, .rst_ni, .run_i,
    .psc_i (ctrl_q[C_PSC +: PSC_W]),
    .tick_o(tick)
  );

  pwm_tmr_regs #(.DW(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .ldok_set_i, .ldok_clr_i,
    .imm_i     (ctrl_q[C_IMM]),
    .rld_cyc_i (rld_cyc),
    .ldok_o    (ldok),
    .pend_o    (pend),
    .init_sh_o (init_sh),
    .init_act_o(init_act),
    .cmp_sh_o  (cmp_sh),
    .cmp_act_o (cmp_act)
  );

  pwm_tmr_outs #(.DW(CNT_W)) i_outs (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .cnt_i  (cnt_q),
    .cmp_i  (cmp_act),
    .indep_i(ctrl_q[C_INDEP]),
    .en_a_i (ctrl_q[C_ENA]),
    .en_b_i (ctrl_q[C_ENB]),
    .match_o(match),
    .pwm_a_o,
    .pwm_b_o
  );

  // counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) begin
      if (match[1]) cnt_q <= $signed(init_act);
      else          cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // reload opportunity counting
  assign opp = !ctrl_q[C_IMM] &&
               ((ctrl_q[C_FULL] && match[1]) || (ctrl_q[C_HALF] && match[0]));
  assign rld_cyc = opp && (opp_q == ctrl_q[C_LDFQ +: LDFQ_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opp_q <= '0;
    else if (rld_cyc) opp_q <= '0;
    else if (opp)     opp_q <= opp_q + LDFQ_W'(1);
  end

  // control, status, interrupt enable
  always_comb begin
    sts_set = '0;
    sts_set[NCMP-1:0] = match;
    sts_set[S_RLD]    = rld_cyc;
    sts_set[S_RERR]   = rld_cyc && !ldok && pend;
    sts_clr = (wr_en_i && addr_i == ADDR_W'(A_STS)) ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sts_q  <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(A_CTRL)) ctrl_q <= wdata_i;
      if (wr_en_i && addr_i == ADDR_W'(A_IEN))  ien_q  <= wdata_i & FLAG_MASK;
      sts_q <= ((sts_q & ~sts_clr) | sts_set) & FLAG_MASK;
    end
  end

  always_comb begin
    sts_view = sts_q;
    sts_view[S_PEND] = pend;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_INIT)) rdata_o = init_sh;
    for (int k = 0; k < NCMP; k++)
      if (addr_i == ADDR_W'(A_CMP0 + k)) rdata_o = cmp_sh[k];
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(A_STS))  rdata_o = sts_view;
    if (addr_i == ADDR_W'(A_IEN))  rdata_o = ien_q;
    if (addr_i == ADDR_W'(A_CNT))  rdata_o = cnt_q;
  end

  assign irq_o  = |(sts_q & ien_q);
  assign ldok_o = ldok;
  assign cnt_o  = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q)); // R1
  AST_RERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_cyc && !ldok && pend) |=> sts_q[S_RERR]); // R11
  AST_RLD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_cyc |=> sts_q[S_RLD]); // R11
endmodule

// File: tb/test_pwm_dbuf_timer.sv
module test_pwm_dbuf_timer;
  localparam int CLK_PERIOD = 10;
  // control word bits: psc[2:0] imm[3] full[4] half[5] ldfq[9:6] indep[10] ena[11] enb[12]
  localparam logic [15:0] CT_IMM   = 16'h0008;
  localparam logic [15:0] CT_FULL  = 16'h0010;
  localparam logic [15:0] CT_INDEP = 16'h0400;
  localparam logic [15:0] CT_ENA   = 16'h0800;
  localparam logic [15:0] CT_ENB   = 16'h1000;
  // prescaler vectors: {psc, run clocks, expected ticks}
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{'{0, 20, 20}, '{1, 20, 10}, '{2, 21, 5},
                                   '{3, 40, 5},  '{7, 256, 2}};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, run = 0, lset = 0, lclr = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata, cnt;
  logic ldok, pa, pb, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_dbuf_timer i_pwm_dbuf_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .run_i(run), .ldok_set_i(lset), .ldok_clr_i(lclr),
    .ldok_o(ldok), .cnt_o(cnt), .pwm_a_o(pa), .pwm_b_o(pb), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    addr = 4'(a); #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); run = 1;
    repeat (n) @(negedge clk);
    run = 0;
  endtask

  task automatic step_to(input logic [15:0] v);
    for (int i = 0; i < 300 && cnt != v; i++) ticks(1);
  endtask

  task automatic ldok_pulse();
    @(negedge clk); lset = 1;
    @(negedge clk); lset = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d, c0;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1;
    // reset state
    chk("R1 reset cnt", cnt, 16'h0);
    chk("R6 reset ldok", 16'(ldok), 16'h0);
    chk("R9 reset pwm", {14'h0, pa, pb}, 16'h0);
    chk("R12 reset irq", 16'(irq), 16'h0);
    rd(8, d); chk("R10 reset status", d, 16'h0);

    // long period, immediate load
    wr(7, CT_IMM);
    wr(2, 16'h7fff);
    rd(2, d); chk("R3 shadow readback", d, 16'h7fff);
    ticks(3); chk("R3 active unchanged before commit", cnt, 16'h0);
    ldok_pulse();
    chk("R6 ldok set", 16'(ldok), 16'h1);
    @(negedge clk);
    chk("R5 immediate commit clears ldok", 16'(ldok), 16'h0);

    // prescaler table
    for (int v = 0; v < NVEC; v++) begin
      wr(7, CT_IMM | 16'(VEC[v][0]));
      c0 = cnt;
      ticks(VEC[v][1]);
      chk("R2 prescaler ticks", cnt - c0, 16'(VEC[v][2]));
    end
    wr(7, CT_IMM);

    // wrap at compare 1 to initial count
    wr(0, 16'd100); wr(2, 16'd105);
    ldok_pulse(); @(negedge clk);
    step_to(16'd105);
    chk("R1 reaches compare 1", cnt, 16'd105);
    ticks(1); chk("R1 wrap to initial", cnt, 16'd100);
    @(negedge clk); run = 0;
    chk("R1 hold while stopped", cnt, 16'd100);
    // init write ignored while ldok set
    @(negedge clk); lset = 1;
    @(negedge clk); lset = 0; wr_en = 1; addr = 0; wdata = 16'd50;
    @(negedge clk); wr_en = 0;
    rd(0, d); chk("R6 init write ignored", d, 16'd100);

    // outputs independent
    wr(3, 16'd101); wr(4, 16'd103); wr(5, 16'd102); wr(6, 16'd104);
    wr(7, CT_IMM | CT_INDEP | CT_ENA | CT_ENB);
    ldok_pulse(); @(negedge clk);
    step_to(16'd103);
    chk("R7 A set at cmp2", 16'(pa), 16'h1);
    ticks(1); chk("R7 A cleared at cmp3", {14'h0, pa, pb}, 16'h1);
    ticks(1); chk("R7 B cleared at cmp5", {14'h0, pa, pb}, 16'h0);
    ticks(3); chk("R7 A set again", {14'h0, pa, pb}, 16'h2);
    ticks(1); chk("R7 B set at cmp4", {14'h0, pa, pb}, 16'h3);
    ticks(1); chk("R7 A off B on", {14'h0, pa, pb}, 16'h1);
    // complementary and enables
    wr(7, CT_IMM | CT_ENA | CT_ENB | 16'h0040);
    chk("R8 B inverse of A", {14'h0, pa, pb}, 16'h1);
    wr(7, CT_IMM | CT_ENA);
    chk("R9 B forced low", 16'(pb), 16'h0);
    // coincident set/clear on A
    wr(7, CT_IMM | CT_INDEP | CT_ENA | CT_ENB);
    wr(4, 16'd101);
    ldok_pulse(); @(negedge clk);
    step_to(16'd102);
    chk("R7 clear beats set", 16'(pa), 16'h0);

    // cycle mode, full reload, every 2nd opportunity
    wr(7, CT_FULL | CT_INDEP | CT_ENA | CT_ENB | 16'h0040);
    wr(8, 16'hffff);
    wr(6, 16'd104);
    rd(8, d); chk("R10 pending bit 14 only", d, 16'h4000);
    step_to(16'd105); ticks(1);
    rd(8, d); chk("R4 no reload at 1st opportunity", d & 16'h1000, 16'h0);
    chk("R10 cmp1 match flag", d & 16'h0002, 16'h0002);
    step_to(16'd105); ticks(1);
    rd(8, d); chk("R11 reload and error flags", d & 16'h7000, 16'h7000);
    wr(9, 16'h2000);
    chk("R12 irq on enabled error", 16'(irq), 16'h1);
    wr(8, 16'h6000);
    rd(8, d); chk("R10 W1C clears, pending kept", d & 16'h6000, 16'h4000);
    chk("R12 irq drops", 16'(irq), 16'h0);
    ldok_pulse();
    step_to(16'd105); ticks(1);
    chk("R4 ldok held until Nth opportunity", 16'(ldok), 16'h1);
    step_to(16'd105); ticks(1);
    chk("R4 commit at reload cycle", 16'(ldok), 16'h0);
    rd(8, d); chk("R11 no error when ldok set", d & 16'h6000, 16'h0);
    ldok_pulse();
    @(negedge clk); lclr = 1;
    @(negedge clk); lclr = 0;
    chk("R6 clear input drops ldok", 16'(ldok), 16'h0);

    finish_run();
  end
endmodule